// File: doc/BRIEF.md
# Register-Pair Word ALU

This unit performs sixteen-bit arithmetic on a register pair whose upper byte is the Y register and whose lower byte is the accumulator. It adds a memory word to the pair, subtracts it, compares against it, multiplies the two bytes of the pair together, and increments or decrements the memory word itself. The memory word arrives already assembled from two consecutive bytes; fetching those bytes and forming their addresses is done elsewhere.

Each accepted operation is registered, so results and flags appear one clock after the request. The block reports the sixteen-bit result, whether it is to be written and whether the destination is the pair or the memory word, and the five condition flags (negative, overflow, half-carry, zero, carry), each with its own update enable so that the status register outside keeps every flag the operation does not touch. Half-carry and overflow are judged on the upper byte, since that is where the final carry chain of the word ends.

Top module: `word_alu`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high exactly one clock later; with `in_valid` low, the next cycle has `out_valid`, `wr_en` and every `upd_*` low.
- R2: Operation code 0 (add) gives `result` = pair + memory word modulo 65536, writes it to the pair (`wr_en`=1, `wr_mem`=0), and sets C to the carry out of bit 15.
- R3: Operation code 1 (subtract) first forms the addend as the two's complement of the memory word truncated to 16 bits, then behaves as the add; C is the carry out of that addition, so subtracting zero gives C=0.
- R4: For add and subtract, H is 1 exactly when bits 11..8 of the result are numerically below bits 11..8 of the old pair.
- R5: For add and subtract, V is 1 exactly when bit 15 of the old pair equals bit 15 of the addend and bit 15 of the result differs from it.
- R6: Whenever N or Z is updated, N equals bit 15 of `result` and Z is 1 only when all 16 bits of `result` are zero.
- R7: Operation code 2 (compare) gives `result` = pair − memory word modulo 65536 with `wr_en`=0, sets C to 1 when the pair is unsigned greater than or equal to the memory word, and updates only N, Z and C.
- R8: Operation codes 3 (increment) and 4 (decrement) give `result` = memory word plus or minus one modulo 65536, written to memory (`wr_en`=1, `wr_mem`=1), and update only N and Z.
- R9: Operation code 5 (multiply) gives `result` = pair[15:8] × pair[7:0] unsigned, written to the pair, and updates only N and Z.
- R10: Add and subtract update all five flags; operation codes 6 and 7 write nothing and update no flag; every flag output whose update enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 3 | Operation code (0 add, 1 subtract, 2 compare, 3 increment, 4 decrement, 5 multiply) |
| pair_in | input | 16 | Register pair, Y in the upper byte, accumulator in the lower |
| mem_in | input | 16 | Memory word operand |
| out_valid | output | 1 | Result and flags valid |
| result | output | 16 | Sixteen-bit result |
| wr_en | output | 1 | Result is to be written |
| wr_mem | output | 1 | Destination is the memory word (1) or the pair (0) |
| flag_n | output | 1 | Negative flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| upd_n | output | 1 | Update enable for N |
| upd_v | output | 1 | Update enable for V |
| upd_h | output | 1 | Update enable for H |
| upd_z | output | 1 | Update enable for Z |
| upd_c | output | 1 | Update enable for C |

## Verification
The carry out of the lower byte and the half-carry and overflow judgements on the upper byte fall in the same cycle, and the upper byte only sees the lower carry after it has been added in. Directed vectors such as 0x0F80 plus 0x0080 and 0x7FFF plus 0x0001 force the lower-byte carry to be the very event that moves the upper nibble or the sign, and random pairs with random operation codes cover the rest. Every result, destination, flag and enable is compared against a bench model that computes the byte-wise sums on its own.

// File: rtl/word_alu_pkg.sv
`timescale 1ns/1ps
package word_alu_pkg;

   typedef enum logic [2:0] {
      WOP_ADD  = 3'd0,
      WOP_SUB  = 3'd1,
      WOP_CMP  = 3'd2,
      WOP_INC  = 3'd3,
      WOP_DEC  = 3'd4,
      WOP_MUL  = 3'd5,
      WOP_RSV6 = 3'd6,
      WOP_RSV7 = 3'd7
   } wop_e;

   typedef struct packed {
      logic n;
      logic v;
      logic h;
      logic z;
      logic c;
   } wflags_t;

   localparam int NIBBLE_W = 4;

endpackage

// File: rtl/word_alu_addsub.sv
`timescale 1ns/1ps
module word_alu_addsub #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] pair_i,
   input  logic [2*BYTE_W-1:0] mem_i,
   input  logic                sub_i,
   output logic [2*BYTE_W-1:0] sum_o,
   output logic                carry_o,
   output logic                half_o,
   output logic                ovf_o
);
   import word_alu_pkg::*;

   localparam int WORD_W = 2 * BYTE_W;

   logic [WORD_W-1:0] addend;
   logic [BYTE_W:0]   lo_sum;
   logic [BYTE_W:0]   hi_sum;

   // subtract negates the memory word first, truncated to the word width
   always_comb begin
      if (sub_i) addend = ~mem_i + WORD_W'(1);
      else       addend = mem_i;
   end

   always_comb begin
      lo_sum = {1'b0, pair_i[BYTE_W-1:0]} + {1'b0, addend[BYTE_W-1:0]};
      hi_sum = {1'b0, pair_i[WORD_W-1:BYTE_W]} + {1'b0, addend[WORD_W-1:BYTE_W]}
             + {{BYTE_W{1'b0}}, lo_sum[BYTE_W]};
   end

   assign sum_o   = {hi_sum[BYTE_W-1:0], lo_sum[BYTE_W-1:0]};
   assign carry_o = hi_sum[BYTE_W];
   assign half_o  = hi_sum[NIBBLE_W-1:0] < pair_i[BYTE_W+NIBBLE_W-1:BYTE_W];
   assign ovf_o   = ~(pair_i[WORD_W-1] ^ addend[WORD_W-1])
                  & (hi_sum[BYTE_W-1] ^ pair_i[WORD_W-1]);

endmodule

// File: rtl/word_alu_cmp.sv
`timescale 1ns/1ps
module word_alu_cmp #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] pair_i,
   input  logic [2*BYTE_W-1:0] mem_i,
   output logic [2*BYTE_W-1:0] diff_o,
   output logic                no_borrow_o
);
   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W:0] lo_diff;
   logic [BYTE_W:0] hi_diff;

   // lower-byte borrow ripples into the upper byte
   always_comb begin
      lo_diff = {1'b0, pair_i[BYTE_W-1:0]} - {1'b0, mem_i[BYTE_W-1:0]};
      hi_diff = {1'b0, pair_i[WORD_W-1:BYTE_W]} - {1'b0, mem_i[WORD_W-1:BYTE_W]}
              - {{BYTE_W{1'b0}}, lo_diff[BYTE_W]};
   end

   assign diff_o      = {hi_diff[BYTE_W-1:0], lo_diff[BYTE_W-1:0]};
   assign no_borrow_o = ~hi_diff[BYTE_W];

endmodule

// File: rtl/word_alu_step.sv
`timescale 1ns/1ps
module word_alu_step #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] mem_i,
   input  logic                dec_i,
   output logic [2*BYTE_W-1:0] next_o
);
   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W:0]   lo_next;
   logic [BYTE_W-1:0] hi_next;
   logic [BYTE_W-1:0] lo_delta;
   logic [BYTE_W-1:0] hi_delta;

   // decrement adds all-ones to each byte; the lower carry means "no borrow"
   always_comb begin
      lo_delta = dec_i ? {BYTE_W{1'b1}} : BYTE_W'(1);
      hi_delta = dec_i ? {BYTE_W{1'b1}} : '0;
      lo_next  = {1'b0, mem_i[BYTE_W-1:0]} + {1'b0, lo_delta};
      hi_next  = mem_i[WORD_W-1:BYTE_W] + hi_delta + {{(BYTE_W-1){1'b0}}, lo_next[BYTE_W]};
   end

   assign next_o = {hi_next, lo_next[BYTE_W-1:0]};

endmodule

// File: rtl/word_alu_mul.sv
`timescale 1ns/1ps
module word_alu_mul #(
   parameter int BYTE_W   = 8,
   parameter int MUL_IMPL = 0
) (
   input  logic [BYTE_W-1:0]   hi_i,
   input  logic [BYTE_W-1:0]   lo_i,
   output logic [2*BYTE_W-1:0] prod_o
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (MUL_IMPL == 0) begin : g_operator
         assign prod_o = WORD_W'(hi_i) * WORD_W'(lo_i);
      end else begin : g_shift_add
         logic [WORD_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < BYTE_W; i++) begin
               if (lo_i[i]) acc = acc + (WORD_W'(hi_i) << i);
            end
         end
         assign prod_o = acc;
      end
   endgenerate

endmodule

// File: rtl/word_alu.sv
`timescale 1ns/1ps
module word_alu #(
   parameter int BYTE_W   = 8,
   parameter int MUL_IMPL = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [2:0]          op,
   input  logic [2*BYTE_W-1:0] pair_in,
   input  logic [2*BYTE_W-1:0] mem_in,
   output logic                out_valid,
   output logic [2*BYTE_W-1:0] result,
   output logic                wr_en,
   output logic                wr_mem,
   output logic                flag_n,
   output logic                flag_v,
   output logic                flag_h,
   output logic                flag_z,
   output logic                flag_c,
   output logic                upd_n,
   output logic                upd_v,
   output logic                upd_h,
   output logic                upd_z,
   output logic                upd_c
);
   import word_alu_pkg::*;

   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (BYTE_W < NIBBLE_W) begin : g_bad_width
         $error("word_alu: BYTE_W must cover at least one nibble");
      end
      if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_mul
         $error("word_alu: MUL_IMPL must be 0 or 1");
      end
   endgenerate

   wop_e op_e;
   assign op_e = wop_e'(op);

   logic [WORD_W-1:0] as_sum, cmp_diff, step_next, mul_prod;
   logic              as_c, as_h, as_v, cmp_nb;

   word_alu_addsub #(.BYTE_W(BYTE_W)) u_addsub (
      .pair_i (pair_in),
      .mem_i  (mem_in),
      .sub_i  (op_e == WOP_SUB),
      .sum_o  (as_sum),
      .carry_o(as_c),
      .half_o (as_h),
      .ovf_o  (as_v)
   );

   word_alu_cmp #(.BYTE_W(BYTE_W)) u_cmp (
      .pair_i     (pair_in),
      .mem_i      (mem_in),
      .diff_o     (cmp_diff),
      .no_borrow_o(cmp_nb)
   );

   word_alu_step #(.BYTE_W(BYTE_W)) u_step (
      .mem_i (mem_in),
      .dec_i (op_e == WOP_DEC),
      .next_o(step_next)
   );

   word_alu_mul #(.BYTE_W(BYTE_W), .MUL_IMPL(MUL_IMPL)) u_mul (
      .hi_i  (pair_in[WORD_W-1:BYTE_W]),
      .lo_i  (pair_in[BYTE_W-1:0]),
      .prod_o(mul_prod)
   );

   logic [WORD_W-1:0] res_d;
   logic              wr_d, mem_d;
   wflags_t           val_d, upd_d, flag_d;

   always_comb begin
      res_d = '0;
      wr_d  = 1'b0;
      mem_d = 1'b0;
      val_d = '0;
      upd_d = '0;
      unique case (op_e)
         WOP_ADD, WOP_SUB: begin
            res_d = as_sum;
            wr_d  = 1'b1;
            val_d.c = as_c;
            val_d.h = as_h;
            val_d.v = as_v;
            upd_d = '{n: 1'b1, v: 1'b1, h: 1'b1, z: 1'b1, c: 1'b1};
         end
         WOP_CMP: begin
            res_d   = cmp_diff;
            val_d.c = cmp_nb;
            upd_d   = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b1};
         end
         WOP_INC, WOP_DEC: begin
            res_d = step_next;
            wr_d  = 1'b1;
            mem_d = 1'b1;
            upd_d = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b0};
         end
         WOP_MUL: begin
            res_d = mul_prod;
            wr_d  = 1'b1;
            upd_d = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b0};
         end
         default: begin
            res_d = '0;
         end
      endcase
      val_d.n = res_d[WORD_W-1];
      val_d.z = (res_d == '0);
      if (!in_valid) begin
         wr_d  = 1'b0;
         mem_d = 1'b0;
         upd_d = '0;
      end
      flag_d = val_d & upd_d;
   end

   wflags_t flag_q, upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         wr_mem    <= 1'b0;
         flag_q    <= '0;
         upd_q     <= '0;
      end else begin
         out_valid <= in_valid;
         result    <= in_valid ? res_d : '0;
         wr_en     <= wr_d;
         wr_mem    <= mem_d;
         flag_q    <= flag_d;
         upd_q     <= upd_d;
      end
   end

   assign flag_n = flag_q.n;
   assign flag_v = flag_q.v;
   assign flag_h = flag_q.h;
   assign flag_z = flag_q.z;
   assign flag_c = flag_q.c;
   assign upd_n  = upd_q.n;
   assign upd_v  = upd_q.v;
   assign upd_h  = upd_q.h;
   assign upd_z  = upd_q.z;
   assign upd_c  = upd_q.c;

endmodule

// File: rtl/word_alu_chk.sv
`timescale 1ns/1ps
module word_alu_chk #(
   parameter int BYTE_W   = 8,
   parameter int MUL_IMPL = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [2:0]          op,
   input logic [2*BYTE_W-1:0] pair_in,
   input logic [2*BYTE_W-1:0] mem_in,
   input logic                out_valid,
   input logic [2*BYTE_W-1:0] result,
   input logic                wr_en,
   input logic                wr_mem,
   input logic                flag_n,
   input logic                flag_v,
   input logic                flag_h,
   input logic                flag_z,
   input logic                flag_c,
   input logic                upd_n,
   input logic                upd_v,
   input logic                upd_h,
   input logic                upd_z,
   input logic                upd_c
);
   localparam int WORD_W = 2 * BYTE_W;

   // R1: one-cycle latency
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en && !upd_n && !upd_v && !upd_h && !upd_z && !upd_c));

   // R6: N and Z track the reported word
   a_r6_n_is_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && upd_n) |-> (flag_n == result[WORD_W-1]));
   a_r6_z_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && upd_z) |-> (flag_z == (result == '0)));

   // R7: compare writes nothing and touches only N, Z, C
   a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd2) |=> (!wr_en && upd_c && !upd_v && !upd_h));

   // R8: increment and decrement go to memory and keep C
   a_r8_step_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == 3'd3 || op == 3'd4)) |=> (wr_en && wr_mem && !upd_c && !upd_v));

   // R9: product of the two pair bytes
   a_r9_mul_product: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd5) |=>
         (result == WORD_W'($past(pair_in[WORD_W-1:BYTE_W])) * WORD_W'($past(pair_in[BYTE_W-1:0]))));

   // R10: disabled flags read zero; reserved codes are silent
   a_r10_masked_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_n -> !flag_n) && (!upd_v -> !flag_v) && (!upd_h -> !flag_h)
      && (!upd_z -> !flag_z) && (!upd_c -> !flag_c));
   a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op[2:1] == 2'b11) |=> (!wr_en && $countones({upd_n, upd_v, upd_h, upd_z, upd_c}) == 0));

endmodule

bind word_alu word_alu_chk #(.BYTE_W(BYTE_W), .MUL_IMPL(MUL_IMPL)) u_word_alu_chk (.*);

// File: tb/test_word_alu.sv
`timescale 1ns/1ps
module test_word_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [15:0] pair_in = '0;
   logic [15:0] mem_in = '0;
   logic        out_valid, wr_en, wr_mem;
   logic [15:0] result;
   logic        flag_n, flag_v, flag_h, flag_z, flag_c;
   logic        upd_n, upd_v, upd_h, upd_z, upd_c;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   word_alu i_word_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .pair_in(pair_in), .mem_in(mem_in), .out_valid(out_valid),
      .result(result), .wr_en(wr_en), .wr_mem(wr_mem),
      .flag_n(flag_n), .flag_v(flag_v), .flag_h(flag_h), .flag_z(flag_z), .flag_c(flag_c),
      .upd_n(upd_n), .upd_v(upd_v), .upd_h(upd_h), .upd_z(upd_z), .upd_c(upd_c)
   );

   // packed view: {result, wr_en, wr_mem, n v h z c, upd n v h z c}
   function automatic logic [27:0] model(input logic [2:0] o, input logic [15:0] p, input logic [15:0] m);
      logic [15:0] r, addend;
      logic [8:0]  lo, hi;
      logic        w, d, fn, fv, fh, fz, fc;
      logic [4:0]  u;
      r = '0; w = 0; d = 0; fv = 0; fh = 0; fc = 0; u = 5'b00000;
      case (o)
         3'd0, 3'd1: begin
            addend = (o == 3'd1) ? 16'((17'h10000 - {1'b0, m}) & 17'hFFFF) : m;
            lo = {1'b0, p[7:0]} + {1'b0, addend[7:0]};
            hi = {1'b0, p[15:8]} + {1'b0, addend[15:8]} + {8'd0, lo[8]};
            r  = {hi[7:0], lo[7:0]};
            fc = hi[8];
            fh = (r[11:8] < p[11:8]);
            fv = (p[15] == addend[15]) && (r[15] != p[15]);
            w = 1; u = 5'b11111;
         end
         3'd2: begin
            r  = p - m;
            fc = (p >= m);
            u  = 5'b10011;
         end
         3'd3: begin r = m + 16'd1; w = 1; d = 1; u = 5'b10010; end
         3'd4: begin r = m - 16'd1; w = 1; d = 1; u = 5'b10010; end
         3'd5: begin r = 16'(p[15:8]) * 16'(p[7:0]); w = 1; u = 5'b10010; end
         default: begin r = '0; end
      endcase
      fn = r[15];
      fz = (r == 16'd0);
      return {r, w, d, {fn, fv, fh, fz, fc} & u, u};
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R7";
         3'd3, 3'd4: return "R8";
         3'd5: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [27:0] observed();
      return {result, wr_en, wr_mem, flag_n, flag_v, flag_h, flag_z, flag_c,
              upd_n, upd_v, upd_h, upd_z, upd_c};
   endfunction

   // called at a negative edge; returns at the next one with outputs settled
   task automatic run_op(input logic [2:0] o, input logic [15:0] p, input logic [15:0] m);
      logic [27:0] e, g;
      in_valid = 1'b1; op = o; pair_in = p; mem_in = m;
      @(negedge clk);
      e = model(o, p, m);
      g = observed();
      check("R1", {31'd0, out_valid}, 32'd1);
      check(tag_of(o), {4'd0, g}, {4'd0, e});
      if (o <= 3'd1) begin
         check("R4", {31'd0, flag_h}, {31'd0, e[7]});
         check("R5", {31'd0, flag_v}, {31'd0, e[8]});
      end
      if (g[4]) check("R6", {30'd0, flag_n, flag_z}, {30'd0, result[15], result == 16'd0});
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h2C0FFEE));
      repeat (3) @(negedge clk);
      // reset state, R1
      check("R1", {3'd0, observed(), out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 carry from low byte into high
      run_op(3'd0, 16'h00FF, 16'h0001);
      run_op(3'd0, 16'hFFFF, 16'h0001);              // R2 wrap, C=1, Z=1
      run_op(3'd0, 16'h0F80, 16'h0080);              // R4 low carry drops high nibble
      run_op(3'd0, 16'h7FFF, 16'h0001);              // R5 sign change
      run_op(3'd0, 16'h8000, 16'h8000);              // R5 negative overflow
      run_op(3'd1, 16'h1234, 16'h0000);              // R3 subtract zero, C=0
      run_op(3'd1, 16'h1234, 16'h1234);              // R3 equal, Z=1
      run_op(3'd1, 16'h0000, 16'h0001);              // R3 borrow through
      run_op(3'd2, 16'h5000, 16'h5000);              // R7 equal
      run_op(3'd2, 16'h4FFF, 16'h5000);              // R7 below
      run_op(3'd2, 16'h0100, 16'h00FF);              // R7 low-byte borrow
      run_op(3'd3, 16'hAAAA, 16'hFFFF);              // R8 increment wrap
      run_op(3'd4, 16'h5555, 16'h0000);              // R8 decrement wrap
      run_op(3'd4, 16'h0000, 16'h0100);              // R8 borrow into high byte
      run_op(3'd5, 16'hFFFF, 16'h1234);              // R9 max product
      run_op(3'd5, 16'h0080, 16'h0000);              // R9 zero product
      run_op(3'd6, 16'h1234, 16'h5678);              // R10 reserved
      run_op(3'd7, 16'hFFFF, 16'hFFFF);              // R10 reserved

      // R1 idle cycle after a request
      in_valid = 1'b0;
      @(negedge clk);
      check("R1", {3'd0, observed(), out_valid}, 32'd0);

      for (int i = 0; i < 600; i++) begin
         run_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom));
      end
      in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule